// File: doc/BRIEF.md
# Debug Breakpoint Halt Controller

This block sits beside a small processor core. It decides when user execution must stop and control must pass to a debug monitor. There are three halt triggers. The first is a falling edge on an external debug pin. The second is a program counter that reaches a programmed breakpoint address. The third is a single-step control bit, which stops the core after one user instruction.

The triggers are merged into one halt event, and that event is taken only while the debug-disable input is low and the block is not already in debug. When a halt is taken, three things happen in the same cycle:
- The in-debug state is set, and `halt_o` is raised and held until the monitor pulses `mon_exit_i`.
- The PC is captured.
- A one-cycle vector pulse tells the core to enter the monitor.

A small register port serves the monitor. Writing the address locations programs the breakpoint. Reading the same locations returns the PC captured at the last halt. A control location holds the step bit and reports which triggers caused the last halt.

After reset, no halt is taken until the first instruction has retired. A pin halt requested early therefore lets the instruction at address 0 run, and the halt lands with the PC at 1.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the breakpoint address, captured PC, step bit and trigger status all read 0, and `halt_o` and `vector_o` are low.
- R2: A halt is taken only while `dbg_off_i` is 0 and `halt_o` is low. Requests that arrive while halted or while `dbg_off_i` is 1 are dropped, not queued.
- R3: The debug pin passes through a two-flop synchroniser. Each high-to-low transition yields exactly one halt request.
- R4: `pc_i` is the next PC to execute. A breakpoint hit occurs in the cycle after a `retire_i` strobe when `pc_i` equals the 13-bit breakpoint. A PC that does not advance cannot hit again.
- R5: With the step bit set, exactly one retired user instruction after `mon_exit_i` produces a halt at the following PC.
- R6: Register addresses are 0, 1 and 2.
  - Writing address 0 sets breakpoint bits 7:0.
  - Writing address 1 sets bits 12:8 from write data bits 4:0, and bits 7:5 are ignored.
  - Reading address 0 returns captured PC bits 7:0, and reading address 1 returns bits 12:8 in data bits 4:0.
- R7: The captured PC equals `pc_i` in the cycle the halt is taken. It is also driven on `halt_pc_o`.
- R8: Before the first retire after reset, a pin request is held pending. It is taken together with the first new PC, so the captured PC is 1 when starting at 0.
- R9: Simultaneous triggers give one halt event. Reading address 2 returns bit0 = step bit, bit1 = step trigger, bit2 = breakpoint trigger and bit3 = pin trigger, all recorded for the last halt.
- R10: `vector_o` is high for exactly the first cycle in which `halt_o` is high. `halt_o` stays high until `mon_exit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_i | input | 13 | Next PC to execute |
| retire_i | input | 1 | One user instruction retired this cycle |
| dbg_pin_i | input | 1 | Asynchronous debug pin, halt on falling edge |
| dbg_off_i | input | 1 | 1 disables all halts |
| mon_exit_i | input | 1 | Monitor leaves debug, clears the halt |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| halt_o | output | 1 | In-debug / halt request |
| vector_o | output | 1 | One-cycle enter-monitor pulse |
| halt_pc_o | output | 13 | PC captured at last halt |

## Verification
Two situations are the hardest to reach from the ports.

The first is the post-reset skid. The bench drives the pin low right after reset, before any retire, and waits several cycles to confirm that no halt has been taken. It then retires a single instruction and expects the halt with PC 1 and the pin trigger recorded.

The second is a coincident step and breakpoint hit. The bench programs the breakpoint to the PC that the single stepped instruction lands on. It expects one vector pulse with both trigger bits set.

Stalled-PC and nested-request cases are driven by exiting the monitor without retiring, and by toggling the pin while already halted.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] REG_BP_LO = 2'd0;
  localparam logic [REG_ADDR_W-1:0] REG_BP_HI = 2'd1;
  localparam logic [REG_ADDR_W-1:0] REG_CTRL  = 2'd2;

  typedef struct packed {
    logic pin;
    logic match;
    logic step;
  } halt_src_t;
endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;  // idle-high pin
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  assert_single_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs
  import dbg_halt_pkg::*;
#(
  parameter int unsigned PC_W   = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [PC_W-1:0]       halt_pc_i,
  input  halt_src_t             src_i,
  output logic [PC_W-1:0]       bp_o,
  output logic                  step_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int unsigned HI_W = PC_W - DATA_W;

  logic [PC_W-1:0] bp_q;
  logic            step_q;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:HI_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q   <= '0;
      step_q <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        REG_BP_LO: bp_q[DATA_W-1:0]    <= wdata_i;
        REG_BP_HI: bp_q[PC_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        REG_CTRL:  step_q              <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // same addresses read back the captured halt PC, not the breakpoint
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_BP_LO: rdata_o = halt_pc_i[DATA_W-1:0];
      REG_BP_HI: rdata_o[HI_W-1:0] = halt_pc_i[PC_W-1:DATA_W];
      REG_CTRL: begin
        rdata_o[0]   = step_q;
        rdata_o[3:1] = src_i;
      end
      default: ;
    endcase
  end

  assign bp_o   = bp_q;
  assign step_o = step_q;

  assert_bp_lo_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_BP_LO) |=> bp_o[DATA_W-1:0] == $past(wdata_i));
  assert_bp_hi_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_BP_HI) |=> $stable(bp_o[PC_W-1:DATA_W]));
endmodule

// File: rtl/dbg_halt_arb.sv
module dbg_halt_arb
  import dbg_halt_pkg::*;
#(
  parameter int unsigned PC_W = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pc_i,
  input  logic            retire_i,
  input  logic            fall_i,
  input  logic [PC_W-1:0] bp_i,
  input  logic            step_i,
  input  logic            dbg_off_i,
  input  logic            exit_i,
  output logic            in_debug_o,
  output logic            vector_o,
  output logic [PC_W-1:0] halt_pc_o,
  output halt_src_t       src_o
);
  logic            retire_q, boot_q, pend_q, in_debug_q, vector_q;
  logic [PC_W-1:0] halt_pc_q;
  halt_src_t       src_q, hit;
  logic            gate, boot_ok, take;

  assign gate    = !dbg_off_i && !in_debug_q;
  assign boot_ok = boot_q || retire_q;  // first new PC after reset

  always_comb begin
    hit.match = retire_q && (pc_i == bp_i);
    hit.step  = retire_q && step_i;
    hit.pin   = (fall_i || pend_q) && boot_ok;
  end

  assign take = gate && (hit != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retire_q   <= 1'b0;
      boot_q     <= 1'b0;
      pend_q     <= 1'b0;
      in_debug_q <= 1'b0;
      vector_q   <= 1'b0;
      halt_pc_q  <= '0;
      src_q      <= '0;
    end else begin
      retire_q <= retire_i;
      vector_q <= take;
      if (retire_q) boot_q <= 1'b1;
      // pin request waits only for the boot skid; dropped when gated
      if (!gate || take)  pend_q <= 1'b0;
      else if (fall_i)    pend_q <= 1'b1;
      if (take) begin
        in_debug_q <= 1'b1;
        halt_pc_q  <= pc_i;
        src_q      <= hit;
      end else if (exit_i) begin
        in_debug_q <= 1'b0;
      end
    end
  end

  assign in_debug_o = in_debug_q;
  assign vector_o   = vector_q;
  assign halt_pc_o  = halt_pc_q;
  assign src_o      = src_q;

  assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_debug_q) |-> $past(!dbg_off_i));
  assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_debug_q) |-> halt_pc_q == $past(pc_i));
  assert_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_debug_q) |-> src_q != '0);
  assert_skid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_debug_q |-> boot_q);
  assert_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_q |-> in_debug_q ##1 !vector_q);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_debug_q && !exit_i) |=> in_debug_q);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int unsigned PC_W        = 13,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PC_W-1:0]       pc_i,
  input  logic                  retire_i,
  input  logic                  dbg_pin_i,
  input  logic                  dbg_off_i,
  input  logic                  mon_exit_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  halt_o,
  output logic                  vector_o,
  output logic [PC_W-1:0]       halt_pc_o
);
  logic            pin_fall;
  logic [PC_W-1:0] bp;
  logic            step;
  halt_src_t       src;

  dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (dbg_pin_i),
    .fall_o (pin_fall)
  );

  dbg_bp_regs #(.PC_W(PC_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .halt_pc_i (halt_pc_o),
    .src_i     (src),
    .bp_o      (bp),
    .step_o    (step),
    .rdata_o   (reg_rdata_o)
  );

  dbg_halt_arb #(.PC_W(PC_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_i       (pc_i),
    .retire_i   (retire_i),
    .fall_i     (pin_fall),
    .bp_i       (bp),
    .step_i     (step),
    .dbg_off_i  (dbg_off_i),
    .exit_i     (mon_exit_i),
    .in_debug_o (halt_o),
    .vector_o   (vector_o),
    .halt_pc_o  (halt_pc_o),
    .src_o      (src)
  );

  assert_vec_in_halt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> halt_o);
endmodule

// File: tb/dbg_halt_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_tb_top;
  localparam int CLK_NS = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] pc_i = '0;
  logic        retire_i = 1'b0;
  logic        dbg_pin_i = 1'b1;
  logic        dbg_off_i = 1'b0;
  logic        mon_exit_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        halt_o, vector_o;
  logic [12:0] halt_pc_o;

  int tests = 0, fails = 0, vec_cnt = 0, retired = 0;
  bit done = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  dbg_halt_ctrl dut_i (
    .clk_i, .rst_ni, .pc_i, .retire_i, .dbg_pin_i, .dbg_off_i, .mon_exit_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .halt_o, .vector_o, .halt_pc_o
  );

  always @(negedge clk_i) if (vector_o) vec_cnt++;

  typedef struct packed {
    logic [12:0] bp;
    logic        hit;
    logic [12:0] exp_pc;
  } vec_t;

  localparam vec_t TAB [4] = '{
    '{bp: 13'd5,      hit: 1'b1, exp_pc: 13'd5},
    '{bp: 13'd0,      hit: 1'b0, exp_pc: 13'd0},
    '{bp: 13'h1FFF,   hit: 1'b0, exp_pc: 13'd0},
    '{bp: 13'd3,      hit: 1'b1, exp_pc: 13'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; pc_i = '0; retire_i = 0; dbg_pin_i = 1; dbg_off_i = 0;
    mon_exit_i = 0; reg_we_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // one instruction retires; PC advances; returns at the negedge where a halt is visible
  task automatic step_core();
    @(negedge clk_i);
    retire_i = 1;
    @(negedge clk_i);
    retire_i = 0; pc_i = pc_i + 13'd1; retired++;
    @(negedge clk_i);
  endtask

  task automatic mon_exit();
    @(negedge clk_i);
    mon_exit_i = 1;
    @(negedge clk_i);
    mon_exit_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v0;

    // R1 reset state
    do_reset();
    rd(2'd0, d); chk("R1 pc lo", d, 0);
    rd(2'd1, d); chk("R1 pc hi", d, 0);
    rd(2'd2, d); chk("R1 ctrl", d, 0);
    chk("R1 halt_o", halt_o, 0);
    chk("R1 vector_o", vector_o, 0);

    // R4 R7 breakpoint table
    for (int i = 0; i < 4; i++) begin
      do_reset();
      wr(2'd0, TAB[i].bp[7:0]);
      wr(2'd1, {3'b0, TAB[i].bp[12:8]});
      for (int s = 0; s < 8; s++) begin
        if (halt_o) break;
        step_core();
      end
      chk($sformatf("R4 hit vec%0d", i), halt_o, TAB[i].hit);
      rd(2'd0, d); chk($sformatf("R7 pc vec%0d", i), d, TAB[i].exp_pc[7:0]);
    end

    // R8 R3 R10: pin low before first retire, skid to PC 1
    do_reset();
    wr(2'd1, 8'h1F); wr(2'd0, 8'hFF);
    @(negedge clk_i); dbg_pin_i = 0;
    repeat (6) @(negedge clk_i);
    chk("R8 no halt before retire", halt_o, 0);
    dbg_pin_i = 1;
    v0 = vec_cnt;
    @(negedge clk_i); retire_i = 1;
    @(negedge clk_i); retire_i = 0; pc_i = 13'd1;
    @(negedge clk_i);
    chk("R10 halt_o first cycle", halt_o, 1);
    chk("R10 vector first cycle", vector_o, 1);
    @(negedge clk_i);
    chk("R10 vector gone", vector_o, 0);
    chk("R10 halt held", halt_o, 1);
    rd(2'd0, d); chk("R8 skid pc", d, 1);
    rd(2'd2, d); chk("R3 pin src", d, 8'h08);
    chk("R3 one event", vec_cnt - v0, 1);

    // R2 nested pin while halted dropped
    v0 = vec_cnt;
    @(negedge clk_i); dbg_pin_i = 0;
    repeat (5) @(negedge clk_i); dbg_pin_i = 1;
    repeat (4) @(negedge clk_i);
    chk("R2 no nested vector", vec_cnt - v0, 0);
    mon_exit();
    repeat (4) @(negedge clk_i);
    chk("R2 dropped not queued", halt_o, 0);

    // R5 single step (pc 1 -> 2)
    wr(2'd2, 8'h01);
    @(negedge clk_i); dbg_pin_i = 0;  // pin edge to re-enter monitor at pc 1
    repeat (5) @(negedge clk_i); dbg_pin_i = 1;
    chk("R3 pin halt again", halt_o, 1);
    v0 = retired;
    mon_exit();
    step_core();
    chk("R5 step halt", halt_o, 1);
    chk("R5 one retire", retired - v0, 1);
    rd(2'd0, d); chk("R5 step pc", d, 2);
    rd(2'd2, d); chk("R9 step src", d, 8'h03);

    // R9 step and breakpoint together at pc 3
    wr(2'd0, 8'h03); wr(2'd1, 8'h00);
    v0 = vec_cnt;
    mon_exit();
    step_core();
    chk("R9 halt", halt_o, 1);
    rd(2'd2, d); chk("R9 both src", d, 8'h07);
    chk("R9 one vector", vec_cnt - v0, 1);

    // R4 stalled PC equal to breakpoint does not re-halt
    wr(2'd2, 8'h00);
    mon_exit();
    repeat (5) @(negedge clk_i);
    chk("R4 stalled no rehalt", halt_o, 0);

    // R2 disabled: breakpoint at 5 passes
    dbg_off_i = 1;
    wr(2'd0, 8'h05);
    step_core(); step_core();
    chk("R2 dbg_off no halt", halt_o, 0);
    dbg_off_i = 0;

    // R6 high bits, upper write bits ignored
    do_reset();
    wr(2'd0, 8'h34); wr(2'd1, 8'hF2);
    @(negedge clk_i); pc_i = 13'h1233;
    step_core();
    chk("R6 hi match", halt_o, 1);
    rd(2'd0, d); chk("R6 pc lo", d, 8'h34);
    rd(2'd1, d); chk("R6 pc hi", d, 8'h12);
    chk("R7 halt_pc_o", halt_pc_o, 13'h1234);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule